// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel flash bus. It watches every host write cycle, which carries a low address, the sector address bits and a data byte. It recognises the multi-cycle unlock command sequences used to start embedded operations. When a sequence completes, it emits a one-cycle operation pulse. The pulse carries the operation kind and the address and data of the final write. The array programming and erase engines act on that pulse and report back through a busy input.

Every program or erase command must begin with the two-cycle unlock prefix. Any cycle that breaks a sequence returns the decoder to read mode. A few single-cycle commands need no prefix: array reset, erase suspend and erase resume. The decoder also tracks whether a sector erase is running or suspended, so that suspend and resume are accepted only when they make sense.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid` is 0, `mode` is 0 (read), and no operation is pending.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h followed by any write emits kind 1 (program), with `op_addr` = {`wr_sec`, `wr_addr`} and `op_data` = `wr_data` of that fourth write.
- R3: The six-cycle sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h emits kind 2 (chip erase).
- R4: The same five set-up cycles followed by 30h at any address emit kind 3 (sector erase), with `op_addr[16:11]` holding the sector number, and set `mode` to 1 (erasing) in the same cycle.
- R5: A write of F0h at any address, in any sequence state and even while `busy` is high, emits kind 0 (reset) and clears any partial sequence.
- R6: A write whose address or data does not match the next expected cycle emits nothing and returns the decoder to idle, so later cycles of the broken sequence do not complete it.
- R7: While `busy` is high, writes other than F0h and an honoured B0h are ignored: they emit nothing and leave a partial sequence intact.
- R8: B0h emits kind 4 (suspend) and sets `mode` to 2 (suspended) only when `mode` is 1 and `busy` is high; otherwise it emits nothing.
- R9: A single write of 30h from idle while `mode` is 2 and `busy` is low emits kind 5 (resume) and sets `mode` back to 1.
- R10: In `mode` 1, a falling edge of `busy` returns `mode` to 0 one clock later.
- R11: `op_valid` rises on the clock edge that captures the completing write and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write cycle strobe, one clock per write |
| wr_addr | input | 11 | Low address bits of the write |
| wr_sec | input | 6 | Sector address bits of the write |
| wr_data | input | 8 | Data byte of the write |
| busy | input | 1 | Embedded algorithm running |
| op_valid | output | 1 | One-cycle pulse for a decoded operation |
| op_kind | output | 3 | 0 reset, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | 17 | {sector, low address} of the completing write |
| op_data | output | 8 | Data byte of the completing write |
| mode | output | 2 | 0 read, 1 sector erase running, 2 erase suspended |

## Verification
A corrupted sequence state shows up at the ports only when the next matching write would complete, or would fail to complete, a command. So each scenario drives a whole sequence and then an extra cycle that must produce nothing. A wrong mode shows one clock after the event that set it, because the suspend and resume decisions depend on it. The bench therefore checks `mode` in the cycle right after each sector erase, suspend, resume and busy edge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        OP_RESET        = 3'd0,
        OP_PROGRAM      = 3'd1,
        OP_CHIP_ERASE   = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_SUSPEND      = 3'd4,
        OP_RESUME       = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        MODE_READ      = 2'd0,
        MODE_ERASING   = 2'd1,
        MODE_SUSPENDED = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM,
        SQ_ERA,
        SQ_ERA_KEY1,
        SQ_ERA_KEY2
    } seq_e;

    // command byte table, index order is only used through the names below
    localparam int NCODE = 8;
    localparam logic [7:0] CMD_CODES [NCODE] =
        '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h30, 8'hF0, 8'hB0};
    localparam int C_KEY1  = 0;
    localparam int C_KEY2  = 1;
    localparam int C_PGM   = 2;
    localparam int C_ERA   = 3;
    localparam int C_CHIP  = 4;
    localparam int C_SECT  = 5;
    localparam int C_RST   = 6;
    localparam int C_SUSP  = 7;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    output logic             at_a,
    output logic             at_b,
    output logic [NCODE-1:0] code_hit
);
    assign at_a = (addr == AW'(KEY_ADDR_A));
    assign at_b = (addr == AW'(KEY_ADDR_B));

    for (genvar i = 0; i < NCODE; i++) begin : g_code
        assign code_hit[i] = (data == DW'(CMD_CODES[i]));
    end
endmodule

// File: rtl/fcd_mode_track.sv
module fcd_mode_track
    import fcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  busy,
    input  logic  ev_sector,
    input  logic  ev_suspend,
    input  logic  ev_resume,
    output mode_e mode
);
    typedef struct packed {
        mode_e mode;
        logic  busy;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.busy = busy;
        if (ev_sector)
            trk_d.mode = MODE_ERASING;
        else if (ev_suspend)
            trk_d.mode = MODE_SUSPENDED;
        else if (ev_resume)
            trk_d.mode = MODE_ERASING;
        else if (trk_q.mode == MODE_ERASING && trk_q.busy && !busy)
            trk_d.mode = MODE_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.mode <= MODE_READ;
            trk_q.busy <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign mode = trk_q.mode;

    // R10
    erase_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERASING && trk_q.busy && !busy && !ev_sector && !ev_suspend && !ev_resume)
        |=> mode == MODE_READ);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int LOW_AW = 11,
    parameter int SEC_W  = 6,
    parameter int DW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LOW_AW-1:0]       wr_addr,
    input  logic [SEC_W-1:0]        wr_sec,
    input  logic [DW-1:0]           wr_data,
    input  logic                    busy,
    output logic                    op_valid,
    output logic [2:0]              op_kind,
    output logic [SEC_W+LOW_AW-1:0] op_addr,
    output logic [DW-1:0]           op_data,
    output logic [1:0]              mode
);
    localparam int FAW = SEC_W + LOW_AW;

    typedef struct packed {
        seq_e           seq;
        logic           op_valid;
        op_kind_e       op_kind;
        logic [FAW-1:0] op_addr;
        logic [DW-1:0]  op_data;
    } dec_t;

    dec_t d, q;

    logic             at_a, at_b;
    logic [NCODE-1:0] hit;
    logic             ev_sector, ev_suspend, ev_resume;
    mode_e            mode_cur;

    fcd_cycle_match #(.AW(LOW_AW), .DW(DW)) u_match (
        .addr     (wr_addr),
        .data     (wr_data),
        .at_a     (at_a),
        .at_b     (at_b),
        .code_hit (hit)
    );

    fcd_mode_track u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .ev_sector  (ev_sector),
        .ev_suspend (ev_suspend),
        .ev_resume  (ev_resume),
        .mode       (mode_cur)
    );

    always_comb begin
        d          = q;
        d.op_valid = 1'b0;
        ev_sector  = 1'b0;
        ev_suspend = 1'b0;
        ev_resume  = 1'b0;
        if (wr_en) begin
            if (hit[C_RST]) begin
                d.seq      = SQ_IDLE;
                d.op_valid = 1'b1;
                d.op_kind  = OP_RESET;
            end else if (busy) begin
                if (hit[C_SUSP] && mode_cur == MODE_ERASING) begin
                    d.op_valid = 1'b1;
                    d.op_kind  = OP_SUSPEND;
                    ev_suspend = 1'b1;
                end
            end else begin
                d.seq = SQ_IDLE;
                unique case (q.seq)
                    SQ_IDLE: begin
                        if (hit[C_KEY1] && at_a)
                            d.seq = SQ_KEY1;
                        else if (hit[C_SECT] && mode_cur == MODE_SUSPENDED) begin
                            d.op_valid = 1'b1;
                            d.op_kind  = OP_RESUME;
                            ev_resume  = 1'b1;
                        end
                    end
                    SQ_KEY1:
                        if (hit[C_KEY2] && at_b) d.seq = SQ_KEY2;
                    SQ_KEY2: begin
                        if (at_a && hit[C_PGM])      d.seq = SQ_PGM;
                        else if (at_a && hit[C_ERA]) d.seq = SQ_ERA;
                    end
                    SQ_PGM: begin
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_PROGRAM;
                    end
                    SQ_ERA:
                        if (hit[C_KEY1] && at_a) d.seq = SQ_ERA_KEY1;
                    SQ_ERA_KEY1:
                        if (hit[C_KEY2] && at_b) d.seq = SQ_ERA_KEY2;
                    SQ_ERA_KEY2: begin
                        if (hit[C_CHIP] && at_a) begin
                            d.op_valid = 1'b1;
                            d.op_kind  = OP_CHIP_ERASE;
                        end else if (hit[C_SECT]) begin
                            d.op_valid = 1'b1;
                            d.op_kind  = OP_SECTOR_ERASE;
                            ev_sector  = 1'b1;
                        end
                    end
                    default: d.seq = SQ_IDLE;
                endcase
            end
            if (d.op_valid) begin
                d.op_addr = {wr_sec, wr_addr};
                d.op_data = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.seq      <= SQ_IDLE;
            q.op_valid <= 1'b0;
            q.op_kind  <= OP_RESET;
            q.op_addr  <= '0;
            q.op_data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign op_valid = q.op_valid;
    assign op_kind  = q.op_kind;
    assign op_addr  = q.op_addr;
    assign op_data  = q.op_data;
    assign mode     = mode_cur;

    // R11
    op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));

    // R2
    pgm_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_PROGRAM)
        |-> (op_data == $past(wr_data) && op_addr == {$past(wr_sec), $past(wr_addr)}));

    // R4
    sector_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_SECTOR_ERASE) |-> mode == MODE_ERASING);

    // R8
    suspend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_SUSPEND) |-> ($past(busy) && $past(mode) == MODE_ERASING));

    // R8
    suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUSPENDED && $past(mode) != MODE_SUSPENDED)
        |-> (op_valid && op_kind == OP_SUSPEND));

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy)) |-> (op_kind == OP_RESET || op_kind == OP_SUSPEND));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [5:0]  wr_sec = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic [1:0]  mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_sec(wr_sec), .wr_data(wr_data), .busy(busy),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .mode(mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [5:0] s, input logic [7:0] dt);
        wr_en = 1'b1; wr_addr = a; wr_sec = s; wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_op(input string req, input int kind,
                             input logic [16:0] a, input logic [7:0] dt);
        chk(op_valid == 1'b1, req, "op_valid", int'(op_valid), 1);
        chk(int'(op_kind) == kind, req, "op_kind", int'(op_kind), kind);
        chk(op_addr == a, req, "op_addr", int'(op_addr), int'(a));
        chk(op_data == dt, req, "op_data", int'(op_data), int'(dt));
    endtask

    task automatic expect_none(input string req);
        chk(op_valid == 1'b0, req, "no op", int'(op_valid), 0);
    endtask

    task automatic expect_mode(input string req, input int m);
        chk(int'(mode) == m, req, "mode", int'(mode), m);
    endtask

    task automatic unlock();
        wr(11'h555, 6'h0, 8'hAA); wr(11'h2AA, 6'h0, 8'h55);
    endtask

    task automatic erase_setup();
        unlock(); wr(11'h555, 6'h0, 8'h80); unlock();
    endtask

    task automatic t_reset_state();
        expect_none("R1");
        expect_mode("R1", 0);
    endtask

    task automatic t_program();
        wr(11'h555, 6'h0, 8'hAA); expect_none("R2");
        wr(11'h2AA, 6'h0, 8'h55); expect_none("R2");
        wr(11'h555, 6'h0, 8'hA0); expect_none("R2");
        wr(11'h1C3, 6'h15, 8'h5A);
        expect_op("R2", 1, {6'h15, 11'h1C3}, 8'h5A);
        @(negedge clk);
        expect_none("R11");
    endtask

    task automatic t_chip_erase();
        erase_setup(); expect_none("R3");
        wr(11'h555, 6'h0, 8'h10);
        expect_op("R3", 2, {6'h0, 11'h555}, 8'h10);
        expect_mode("R3", 0);
    endtask

    task automatic t_sector_suspend_resume();
        erase_setup();
        wr(11'h123, 6'h2A, 8'h30);
        expect_op("R4", 3, {6'h2A, 11'h123}, 8'h30);
        chk(op_addr[16:11] == 6'h2A, "R4", "sector field", int'(op_addr[16:11]), 'h2A);
        expect_mode("R4", 1);
        busy = 1'b1; @(negedge clk); @(negedge clk);
        wr(11'h000, 6'h2A, 8'hB0);
        expect_op("R8", 4, {6'h2A, 11'h000}, 8'hB0);
        expect_mode("R8", 2);
        busy = 1'b0; @(negedge clk);
        expect_mode("R8", 2);
        wr(11'h010, 6'h00, 8'hB0);
        expect_none("R8");
        expect_mode("R8", 2);
        wr(11'h444, 6'h01, 8'h30);
        expect_op("R9", 5, {6'h01, 11'h444}, 8'h30);
        expect_mode("R9", 1);
        busy = 1'b1; @(negedge clk); @(negedge clk);
        expect_mode("R10", 1);
        busy = 1'b0; @(negedge clk);
        expect_mode("R10", 0);
        wr(11'h444, 6'h01, 8'h30);
        expect_none("R9");
        wr(11'h444, 6'h01, 8'hB0);
        expect_none("R8");
    endtask

    task automatic t_abort();
        unlock();
        wr(11'h555, 6'h0, 8'h55); expect_none("R6");
        wr(11'h555, 6'h0, 8'hA0); expect_none("R6");
        wr(11'h200, 6'h3, 8'h77); expect_none("R6");
        wr(11'h555, 6'h0, 8'hAA);
        wr(11'h123, 6'h0, 8'h55); expect_none("R6");
        wr(11'h555, 6'h0, 8'hA0);
        wr(11'h200, 6'h3, 8'h77); expect_none("R6");
        erase_setup();
        wr(11'h556, 6'h0, 8'h10); expect_none("R6");
        expect_mode("R6", 0);
    endtask

    task automatic t_reset_cmd();
        unlock();
        wr(11'h3A1, 6'h07, 8'hF0);
        expect_op("R5", 0, {6'h07, 11'h3A1}, 8'hF0);
        wr(11'h555, 6'h0, 8'hA0);
        wr(11'h100, 6'h1, 8'h11); expect_none("R5");
        busy = 1'b1;
        wr(11'h7FF, 6'h3F, 8'hF0);
        expect_op("R5", 0, {6'h3F, 11'h7FF}, 8'hF0);
        busy = 1'b0; @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        unlock();
        busy = 1'b1;
        wr(11'h300, 6'h2, 8'h12); expect_none("R7");
        wr(11'h555, 6'h0, 8'hA0); expect_none("R7");
        wr(11'h555, 6'h0, 8'hB0); expect_none("R7");
        busy = 1'b0;
        wr(11'h555, 6'h0, 8'hA0); expect_none("R7");
        wr(11'h0AB, 6'h09, 8'hC3);
        expect_op("R7", 1, {6'h09, 11'h0AB}, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_chip_erase();
        t_sector_suspend_resume();
        t_abort();
        t_reset_cmd();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule